// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address by walking a tree of 32-bit words held in memory. The walk starts from a context table, located by a table pointer and a context number, and descends through at most three levels of directory words. It stops at the first leaf word it meets. A leaf at the first level maps a 16 MB page, a leaf at the second level maps 256 KB, and a leaf at the third level maps 4 KB. Each word is fetched through a request/acknowledge read port, and one walk is in flight at a time.

When the leaf it finds has its referenced bit clear, or the access is a write and the modified bit is clear, the walker sets the bits that are needed and writes the word back to the address it came from before it reports. A failed walk reports a packed code that holds the level where the walk stopped and the kind of fault. When translation is off, the address passes straight through, except that instruction fetches in boot mode are steered into a fixed boot-memory window. Permission checks and caching of translations are left to the blocks around this one.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req` and `mem_we` are all low.
- R2: With translation on, the first read goes to `{ctx_ptr,4'b0} + {ctx_num,2'b0}`. This is the context-table entry, which counts as level 0.
- R3: Bits [1:0] of every fetched word give its type: 0 invalid, 1 directory, 2 leaf, 3 reserved. A directory word at level L (L < 3) points to base `{word[31:2],6'b0}`. The next read goes to that base plus an index times 4, where the index is VA[31:24] for level 1, VA[23:18] for level 2 and VA[17:12] for level 3.
- R4: A leaf at level 1, 2 or 3 gives `pa = {pte[31:8],12'b0} + VA[23:0]`, `VA[17:0]` or `VA[11:0]` respectively. `leaf_level` reports the level and `err_code` is 0.
- R5: A fault ends the walk with `err_code = (level << 8) | (type << 2)`. The type is 1 for an invalid word and 4 for a reserved word, a leaf in the context table, or a directory at level 3. On a fault, `pa` and `leaf_pte` are 0 and `leaf_level` is the failing level.
- R6: The referenced bit is bit 5 and the modified bit is bit 6. If the referenced bit is clear, or the access is a write and the modified bit is clear, the walker writes the leaf back to its own address with bit 5 set, and with bit 6 set on a write, before `done`. `leaf_pte` then shows the updated word.
- R7: When the needed bits are already set, no write is issued and `leaf_pte` equals the fetched word.
- R8: With translation off, `pa` is the zero-extended VA and `err_code` is 0. An instruction fetch in boot mode instead gets `BOOT_BASE | VA[18:0]`.
- R9: `busy` rises in the cycle after an accepted `start` and stays high through the single-cycle `done` pulse. A `start` seen while busy is ignored.
- R10: A memory response with `mem_err` set aborts the walk with type 2, so `err_code = (level << 8) | 8`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (accepted when idle) |
| va | input | 32 | Virtual address |
| is_write | input | 1 | Access is a store |
| is_fetch | input | 1 | Access is an instruction fetch |
| xlat_en | input | 1 | Translation enabled |
| boot_mode | input | 1 | Boot mode for fetches with translation off |
| ctx_ptr | input | PTR_W | Context table pointer (byte address >> 4) |
| ctx_num | input | CTX_W | Context number |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | ERR_W | Packed level and fault type, 0 on success |
| pa | output | 36 | Physical address |
| leaf_pte | output | 32 | Leaf word as it stands after any update |
| leaf_level | output | 2 | Level where the walk ended |
| mem_req | output | 1 | Memory request held until acknowledged |
| mem_we | output | 1 | Request is a write-back |
| mem_addr | output | 36 | Memory word address (byte address) |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Memory response for the current request |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_err | input | 1 | Response carries an error |

## Verification
The bench ends walks at every level and compares each result against a behavioural tree walk. A mistake in the offset width per page size shows up as a wrong `pa` for the 16 MB and 256 KB leaves, and a wrong slice for the context offset sends the first read to the wrong entry. The bench also builds the unexpected-type cases: a leaf in the context table, a reserved word at level 2, and directory and invalid words at level 3. A walker that swaps the type codes or the level field reports a code other than 0x010, 0x210, 0x310 or 0x304. The bench counts memory writes to catch a write-back that is missing, one issued when the bits are already set, or one that forgets the modified bit on a store. It also injects a bus error at level 2, and pulses `start` in the middle of a walk to catch a second, spurious `done`.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   localparam int VA_W    = 32;
   localparam int PA_W    = 36;
   localparam int WORD_W  = 32;
   localparam int LVL_W   = 2;
   localparam int MAX_LVL = 3;
   localparam int PAGE_SH = 12;
   localparam int REF_BIT = 5;
   localparam int MOD_BIT = 6;

   typedef enum logic [1:0] {
      ET_INVALID = 2'd0,
      ET_DIR     = 2'd1,
      ET_LEAF    = 2'd2,
      ET_RSVD    = 2'd3
   } ent_type_e;

   localparam logic [2:0] FT_INVALID = 3'd1;
   localparam logic [2:0] FT_BUS     = 3'd2;
   localparam logic [2:0] FT_UNEXP   = 3'd4;

   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_READ  = 2'd1,
      S_WRITE = 2'd2,
      S_DONE  = 2'd3
   } walk_state_e;

   // virtual-address index slice consumed by directory level g (1..3)
   function automatic int idx_hi(input int g);
      return (g == 1) ? 31 : ((g == 2) ? 23 : 17);
   endfunction

   function automatic int idx_lo(input int g);
      return (g == 1) ? 24 : ((g == 2) ? 18 : 12);
   endfunction
endpackage

// File: rtl/ptw_fetch_addr.sv
module ptw_fetch_addr
   import ptw_pkg::*;
#(
   parameter int CTX_W = 8,
   parameter int PTR_W = 32
) (
   input  logic [PTR_W-1:0]        ctx_ptr,
   input  logic [CTX_W-1:0]        ctx_num,
   input  logic [VA_W-1:PAGE_SH]   va_hi,
   input  logic [WORD_W-1:2]       dir_ptr,
   input  logic [LVL_W-1:0]        next_lvl,
   output logic [PA_W-1:0]         root_addr,
   output logic [PA_W-1:0]         next_addr
);
   localparam int SLOT_SH = 2;

   logic [PA_W-1:0] idx_off [1:MAX_LVL];
   logic [PA_W-1:0] dir_base;
   logic [PA_W-1:0] sel_off;

   for (genvar g = 1; g <= MAX_LVL; g++) begin : g_idx
      localparam int HI = idx_hi(g);
      localparam int LO = idx_lo(g);
      assign idx_off[g] = PA_W'({va_hi[HI:LO], {SLOT_SH{1'b0}}});
   end

   assign root_addr = {ctx_ptr, 4'b0000} + PA_W'({ctx_num, {SLOT_SH{1'b0}}});
   assign dir_base  = {dir_ptr, 6'b000000};

   always_comb begin
      unique case (next_lvl)
         2'd1:    sel_off = idx_off[1];
         2'd2:    sel_off = idx_off[2];
         2'd3:    sel_off = idx_off[3];
         default: sel_off = '0;
      endcase
   end

   assign next_addr = dir_base + sel_off;
endmodule

// File: rtl/ptw_entry_class.sv
module ptw_entry_class
   import ptw_pkg::*;
(
   input  logic [1:0]       ent_type,
   input  logic [LVL_W-1:0] lvl,
   output logic             go_down,
   output logic             is_leaf,
   output logic             fault,
   output logic [2:0]       ftype
);
   always_comb begin
      go_down = 1'b0;
      is_leaf = 1'b0;
      fault   = 1'b0;
      ftype   = FT_INVALID;
      unique case (ent_type_e'(ent_type))
         ET_INVALID: begin
            fault = 1'b1;
            ftype = FT_INVALID;
         end
         ET_DIR: begin
            if (lvl == LVL_W'(MAX_LVL)) begin
               fault = 1'b1;
               ftype = FT_UNEXP;
            end else begin
               go_down = 1'b1;
            end
         end
         ET_LEAF: begin
            if (lvl == '0) begin
               fault = 1'b1;
               ftype = FT_UNEXP;
            end else begin
               is_leaf = 1'b1;
            end
         end
         default: begin
            fault = 1'b1;
            ftype = FT_UNEXP;
         end
      endcase
   end
endmodule

// File: rtl/ptw_leaf_build.sv
module ptw_leaf_build
   import ptw_pkg::*;
(
   input  logic [WORD_W-1:0]    pte,
   input  logic [LVL_W-1:0]     lvl,
   input  logic [idx_lo(1)-1:0] va_lo,
   input  logic                 is_write,
   output logic [PA_W-1:0]      leaf_pa,
   output logic                 need_wb,
   output logic [WORD_W-1:0]    wb_word
);
   logic [PA_W-1:0] page_ofs [1:MAX_LVL];
   logic [PA_W-1:0] sel_ofs;
   logic [PA_W-1:0] page_base;

   // offset width grows with page size: bits below the level's index slice
   for (genvar g = 1; g <= MAX_LVL; g++) begin : g_ofs
      localparam int OHI = idx_lo(g) - 1;
      assign page_ofs[g] = PA_W'(va_lo[OHI:0]);
   end

   always_comb begin
      unique case (lvl)
         2'd1:    sel_ofs = page_ofs[1];
         2'd2:    sel_ofs = page_ofs[2];
         2'd3:    sel_ofs = page_ofs[3];
         default: sel_ofs = '0;
      endcase
   end

   assign page_base = {pte[WORD_W-1:8], {PAGE_SH{1'b0}}};
   assign leaf_pa   = page_base + sel_ofs;

   always_comb begin
      need_wb = !pte[REF_BIT] || (is_write && !pte[MOD_BIT]);
      wb_word = pte;
      wb_word[REF_BIT] = 1'b1;
      if (is_write) wb_word[MOD_BIT] = 1'b1;
   end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int              CTX_W       = 8,
   parameter int              PTR_W       = 32,
   parameter int              ERR_W       = 12,
   parameter int              BOOT_OFS_W  = 19,
   parameter logic [35:0]     BOOT_BASE   = 36'hF_F000_0000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [31:0]         va,
   input  logic                is_write,
   input  logic                is_fetch,
   input  logic                xlat_en,
   input  logic                boot_mode,
   input  logic [PTR_W-1:0]    ctx_ptr,
   input  logic [CTX_W-1:0]    ctx_num,
   output logic                busy,
   output logic                done,
   output logic [ERR_W-1:0]    err_code,
   output logic [35:0]         pa,
   output logic [31:0]         leaf_pte,
   output logic [1:0]          leaf_level,
   output logic                mem_req,
   output logic                mem_we,
   output logic [35:0]         mem_addr,
   output logic [31:0]         mem_wdata,
   input  logic                mem_ack,
   input  logic [31:0]         mem_rdata,
   input  logic                mem_err
);
   // elaboration-time parameter checks
   if (PTR_W + 4 != PA_W) begin : g_bad_ptr
      $error("PTR_W must be PA_W-4");
   end
   if (ERR_W < 10) begin : g_bad_err
      $error("ERR_W must hold level and type fields");
   end
   if (BOOT_OFS_W >= VA_W) begin : g_bad_boot_w
      $error("BOOT_OFS_W too wide");
   end
   if (BOOT_BASE[BOOT_OFS_W-1:0] != '0) begin : g_bad_boot_base
      $error("BOOT_BASE must be aligned to the boot window");
   end

   walk_state_e          state;
   logic [LVL_W-1:0]     lvl_q;
   logic [VA_W-1:0]      va_q;
   logic                 wr_q;
   logic [PA_W-1:0]      addr_q;
   logic [WORD_W-1:0]    wdata_q;
   logic [ERR_W-1:0]     err_q;
   logic [PA_W-1:0]      pa_q;
   logic [WORD_W-1:0]    pte_q;
   logic [LVL_W-1:0]     lvl_out_q;

   logic [PA_W-1:0]      root_addr, next_addr, leaf_pa, pass_pa;
   logic                 go_down, is_leaf, fault, need_wb;
   logic [2:0]           ftype;
   logic [WORD_W-1:0]    wb_word;
   logic [LVL_W-1:0]     lvl_inc;

   assign lvl_inc = lvl_q + LVL_W'(1);

   ptw_fetch_addr #(.CTX_W(CTX_W), .PTR_W(PTR_W)) u_addr (
      .ctx_ptr   (ctx_ptr),
      .ctx_num   (ctx_num),
      .va_hi     (va_q[VA_W-1:PAGE_SH]),
      .dir_ptr   (mem_rdata[WORD_W-1:2]),
      .next_lvl  (lvl_inc),
      .root_addr (root_addr),
      .next_addr (next_addr)
   );

   ptw_entry_class u_class (
      .ent_type (mem_rdata[1:0]),
      .lvl      (lvl_q),
      .go_down  (go_down),
      .is_leaf  (is_leaf),
      .fault    (fault),
      .ftype    (ftype)
   );

   ptw_leaf_build u_leaf (
      .pte      (mem_rdata),
      .lvl      (lvl_q),
      .va_lo    (va_q[idx_lo(1)-1:0]),
      .is_write (wr_q),
      .leaf_pa  (leaf_pa),
      .need_wb  (need_wb),
      .wb_word  (wb_word)
   );

   // pass-through path: boot window for fetches in boot mode
   generate
      if (BOOT_OFS_W > 0) begin : g_boot
         assign pass_pa = (boot_mode && is_fetch)
                        ? (BOOT_BASE | PA_W'(va[BOOT_OFS_W-1:0]))
                        : PA_W'(va);
      end else begin : g_noboot
         assign pass_pa = PA_W'(va);
      end
   endgenerate

   function automatic logic [ERR_W-1:0] pack_err(input logic [LVL_W-1:0] l,
                                                input logic [2:0] t);
      return ERR_W'({l, 8'h00}) | ERR_W'({t, 2'b00});
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         lvl_q     <= '0;
         va_q      <= '0;
         wr_q      <= 1'b0;
         addr_q    <= '0;
         wdata_q   <= '0;
         err_q     <= '0;
         pa_q      <= '0;
         pte_q     <= '0;
         lvl_out_q <= '0;
      end else begin
         unique case (state)
            S_IDLE: begin
               if (start) begin
                  va_q <= va;
                  wr_q <= is_write;
                  if (!xlat_en) begin
                     pa_q      <= pass_pa;
                     err_q     <= '0;
                     pte_q     <= '0;
                     lvl_out_q <= '0;
                     state     <= S_DONE;
                  end else begin
                     addr_q <= root_addr;
                     lvl_q  <= '0;
                     state  <= S_READ;
                  end
               end
            end
            S_READ: begin
               if (mem_ack) begin
                  if (mem_err || fault) begin
                     err_q     <= pack_err(lvl_q, mem_err ? FT_BUS : ftype);
                     pa_q      <= '0;
                     pte_q     <= '0;
                     lvl_out_q <= lvl_q;
                     state     <= S_DONE;
                  end else if (go_down) begin
                     lvl_q  <= lvl_inc;
                     addr_q <= next_addr;
                  end else if (is_leaf) begin
                     err_q     <= '0;
                     pa_q      <= leaf_pa;
                     lvl_out_q <= lvl_q;
                     pte_q     <= need_wb ? wb_word : mem_rdata;
                     wdata_q   <= wb_word;
                     state     <= need_wb ? S_WRITE : S_DONE;
                  end
               end
            end
            S_WRITE: begin
               if (mem_ack) begin
                  if (mem_err) begin
                     err_q <= pack_err(lvl_q, FT_BUS);
                     pa_q  <= '0;
                     pte_q <= '0;
                  end
                  state <= S_DONE;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign busy       = (state != S_IDLE);
   assign done       = (state == S_DONE);
   assign mem_req    = (state == S_READ) || (state == S_WRITE);
   assign mem_we     = (state == S_WRITE);
   assign mem_addr   = addr_q;
   assign mem_wdata  = wdata_q;
   assign err_code   = err_q;
   assign pa         = pa_q;
   assign leaf_pte   = pte_q;
   assign leaf_level = lvl_out_q;

   // R9: completion only inside a walk, as a single pulse
   a_r9_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r9_req_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (busy && !done));
   // R6: write-back carries the referenced bit and targets the fetched word
   a_r6_wb_ref_set: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_wdata[REF_BIT]);
   a_r6_wb_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we) |-> $stable(mem_addr));
   // R5: packed code has no stray bits; a fault reports no address
   a_r5_err_shape: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (err_code[1:0] == 2'b00 && err_code[ERR_W-1:10] == '0));
   a_r5_err_no_pa: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err_code != '0) |-> (pa == '0 && leaf_pte == '0));
endmodule

// File: tb/ptw_walker_test.sv
module ptw_walker_test;
   localparam logic [35:0] BOOT = 36'hF_F000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] va = '0;
   logic        is_write = 1'b0, is_fetch = 1'b0, xlat_en = 1'b0, boot_mode = 1'b0;
   logic [31:0] ctx_ptr = '0;
   logic [7:0]  ctx_num = '0;
   logic        busy, done, mem_req, mem_we;
   logic [11:0] err_code;
   logic [35:0] pa, mem_addr;
   logic [31:0] leaf_pte, mem_wdata;
   logic [1:0]  leaf_level;
   logic        mem_ack = 1'b0, mem_err = 1'b0;
   logic [31:0] mem_rdata = '0;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   ptw_walker uut (
      .clk(clk), .rst_n(rst_n), .start(start), .va(va), .is_write(is_write),
      .is_fetch(is_fetch), .xlat_en(xlat_en), .boot_mode(boot_mode),
      .ctx_ptr(ctx_ptr), .ctx_num(ctx_num), .busy(busy), .done(done),
      .err_code(err_code), .pa(pa), .leaf_pte(leaf_pte), .leaf_level(leaf_level),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .mem_err(mem_err)
   );

   // ---------------- memory model ----------------
   logic [31:0] mem [logic [35:0]];
   int          lat = 0;
   int          wait_cnt = 0;
   logic        bad_en = 1'b0;
   logic [35:0] bad_addr = '0;
   int          wr_count = 0;

   function automatic logic [31:0] rd(input logic [35:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack  = 1'b0;
         mem_err  = 1'b0;
         wait_cnt = 0;
      end else if (mem_req) begin
         if (wait_cnt >= lat) begin
            mem_ack = 1'b1;
            mem_err = bad_en && (mem_addr == bad_addr);
            if (mem_we) begin
               if (!mem_err) begin
                  mem[mem_addr] = mem_wdata;
                  wr_count++;
               end
               mem_rdata = '0;
            end else begin
               mem_rdata = rd(mem_addr);
            end
         end else begin
            wait_cnt++;
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] dir_w(input logic [35:0] base);
      return {base[35:6], 2'b01};
   endfunction

   function automatic logic [31:0] leaf_w(input logic [35:0] page, input bit r, input bit m);
      return {page[35:12], 1'b0, m, r, 3'b000, 2'b10};
   endfunction

   // behavioural walk over the bench memory
   task automatic ref_walk(input logic [31:0] v, input bit wr, input bit fe, input bit en,
                           input bit bt, input logic [31:0] cp, input logic [7:0] cn,
                           output logic [35:0] epa, output logic [11:0] eerr,
                           output logic [31:0] epte, output logic [1:0] elvl,
                           output bit ewb, output logic [35:0] ewa,
                           output logic [31:0] eww);
      logic [35:0] a;
      logic [31:0] w;
      int lv;
      bit fin;
      epa = '0; eerr = '0; epte = '0; elvl = '0; ewb = 0; ewa = '0; eww = '0;
      if (!en) begin
         epa = (bt && fe) ? (BOOT | {17'b0, v[18:0]}) : {4'b0, v};
         return;
      end
      a = {cp, 4'b0} + 36'(cn) * 4;
      lv = 0;
      fin = 0;
      while (!fin) begin
         if (bad_en && a == bad_addr) begin
            eerr = 12'(lv * 256 + 2 * 4); elvl = 2'(lv); fin = 1;
         end else begin
            w = rd(a);
            if (w[1:0] == 2'd0) begin
               eerr = 12'(lv * 256 + 4); elvl = 2'(lv); fin = 1;
            end else if (w[1:0] == 2'd3 || (w[1:0] == 2'd1 && lv == 3)
                         || (w[1:0] == 2'd2 && lv == 0)) begin
               eerr = 12'(lv * 256 + 16); elvl = 2'(lv); fin = 1;
            end else if (w[1:0] == 2'd1) begin
               lv++;
               a = {w[31:2], 6'b0} + ((lv == 1) ? 36'(v[31:24]) * 4 :
                                     (lv == 2) ? 36'(v[23:18]) * 4 : 36'(v[17:12]) * 4);
            end else begin
               epa = {w[31:8], 12'b0} + ((lv == 1) ? 36'(v[23:0]) :
                                        (lv == 2) ? 36'(v[17:0]) : 36'(v[11:0]));
               elvl = 2'(lv);
               ewb = !w[5] || (wr && !w[6]);
               eww = w | 32'h20 | (wr ? 32'h40 : 32'h0);
               ewa = a;
               epte = ewb ? eww : w;
               fin = 1;
            end
         end
      end
   endtask

   task automatic run(input string req, input logic [31:0] v, input bit wr, input bit fe,
                      input bit en, input bit bt, input logic [7:0] cn, input bit poke);
      logic [35:0] epa, ewa;
      logic [11:0] eerr;
      logic [31:0] epte, eww;
      logic [1:0]  elvl;
      bit          ewb;
      int          wc0, cyc;
      ref_walk(v, wr, fe, en, bt, ctx_ptr, cn, epa, eerr, epte, elvl, ewb, ewa, eww);
      wc0 = wr_count;
      @(negedge clk);
      start = 1'b1; va = v; is_write = wr; is_fetch = fe; xlat_en = en;
      boot_mode = bt; ctx_num = cn;
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (!done && cyc < 200) begin
         chk(busy == 1'b1, {req, " R9 busy during walk"}, 64'(busy), 64'd1);
         if (poke && cyc == 1) begin
            start = 1'b1; va = ~v; is_write = ~wr;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      chk(done == 1'b1, {req, " R9 done seen"}, 64'(done), 64'd1);
      chk(err_code == eerr, {req, " R5 err_code"}, 64'(err_code), 64'(eerr));
      chk(pa == epa, {req, " R4 pa"}, 64'(pa), 64'(epa));
      chk(leaf_pte == epte, {req, " R6 leaf_pte"}, 64'(leaf_pte), 64'(epte));
      chk(leaf_level == elvl, {req, " R4 leaf_level"}, 64'(leaf_level), 64'(elvl));
      chk(wr_count == wc0 + (ewb ? 1 : 0), {req, " R7 write count"},
          64'(wr_count), 64'(wc0 + (ewb ? 1 : 0)));
      if (ewb) chk(rd(ewa) == eww, {req, " R6 written word"}, 64'(rd(ewa)), 64'(eww));
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk(busy == 1'b0 && done == 1'b0, {req, " R9 idle after done"},
             64'({busy, done}), 64'd0);
      end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R9 watchdog act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   // ---------------- stimulus ----------------
   localparam logic [35:0] CTXB = 36'h0_0100_0000;
   localparam logic [35:0] T1   = 36'h0_0200_0000;
   localparam logic [35:0] T2   = 36'h0_0300_0000;
   localparam logic [35:0] T3   = 36'h0_0400_0000;

   initial begin
      ctx_ptr = 32'h0010_0000;  // table at byte 0x0100_0000
      // context entries
      mem[CTXB + 3 * 4] = dir_w(T1);
      mem[CTXB + 4 * 4] = 32'h0;                         // invalid
      mem[CTXB + 5 * 4] = leaf_w(36'h1_0000_0000, 1, 1); // leaf in context table
      mem[CTXB + 6 * 4] = 32'h0000_0003;                 // reserved
      // level 1
      mem[T1 + 36'h12 * 4] = dir_w(T2);
      mem[T1 + 36'h7A * 4] = leaf_w(36'h7_0000_0000, 1, 1);
      // level 2 (VA[23:18])
      mem[T2 + 13 * 4] = dir_w(T3);
      mem[T2 + 49 * 4] = leaf_w(36'h5_0000_0000, 1, 0);
      mem[T2 + 50 * 4] = 32'h0000_0003;
      // level 3 (VA[17:12])
      mem[T3 + 5 * 4]  = leaf_w(36'h9_8765_4000, 0, 0);
      mem[T3 + 9 * 4]  = dir_w(36'h0_0500_0000);
      mem[T3 + 10 * 4] = 32'h0;

      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy == 0, "R1 busy in reset", 64'(busy), 0);
      chk(done == 0, "R1 done in reset", 64'(done), 0);
      chk(mem_req == 0 && mem_we == 0, "R1 mem_req in reset", 64'({mem_req, mem_we}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 0 && mem_req == 0, "R1 idle after reset", 64'({busy, mem_req}), 0);

      // R8 pass-through
      run("R8 bypass data",  32'hDEAD_BEEF, 0, 0, 0, 0, 8'd3, 0);
      run("R8 boot fetch",   32'hDEAD_BEEF, 0, 1, 0, 1, 8'd3, 0);
      run("R8 boot data",    32'hDEAD_BEEF, 0, 0, 0, 1, 8'd3, 0);

      // R2 R3 R4 R6: 4 KB leaf, referenced bit set by write-back
      lat = 0;
      run("R2 R3 L3 read",   32'h1234_5678, 0, 0, 1, 0, 8'd3, 0);
      // R7 second read: bits already set
      lat = 2;
      run("R7 L3 reread",    32'h1234_5FFF, 0, 0, 1, 0, 8'd3, 0);
      // R6 write sets the modified bit
      run("R6 L3 write",     32'h1234_5000, 1, 0, 1, 0, 8'd3, 0);
      // R4 256 KB leaf, write sets modified bit
      lat = 1;
      run("R4 L2 write",     32'h12C4_1ABC, 1, 0, 1, 0, 8'd3, 0);
      // R4 R7 16 MB leaf, no write-back needed
      run("R4 L1 write",     32'h7A55_5123, 1, 0, 1, 0, 8'd3, 0);

      // R5 faults
      run("R5 ctx invalid",  32'h1234_5678, 0, 0, 1, 0, 8'd4, 0);
      run("R5 ctx leaf",     32'h1234_5678, 0, 0, 1, 0, 8'd5, 0);
      run("R5 ctx reserved", 32'h1234_5678, 0, 0, 1, 0, 8'd6, 0);
      run("R5 L1 invalid",   32'h2000_0000, 0, 0, 1, 0, 8'd3, 0);
      run("R5 L2 reserved",  32'h12C8_0000, 0, 0, 1, 0, 8'd3, 0);
      run("R5 L3 directory", 32'h1234_9000, 0, 0, 1, 0, 8'd3, 0);
      run("R5 L3 invalid",   32'h1234_A000, 0, 0, 1, 0, 8'd3, 0);

      // R10 bus error on a level-2 read
      bad_en = 1'b1;
      bad_addr = T2 + 44 * 4;
      run("R10 bus error L2", 32'h12B0_0000, 0, 0, 1, 0, 8'd3, 0);
      bad_en = 1'b0;

      // R9 start while busy is ignored
      lat = 3;
      run("R9 start while busy", 32'h1234_5010, 0, 0, 1, 0, 8'd3, 1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule